// File: doc/BRIEF.md
# MSI Snooping Cache-Line Controller

This block keeps the coherence state of a small set of cache lines that belong to one processor's cache. That cache sits on a shared snooping bus. Every cache on the bus sees each transaction in the same order. Each line is Invalid, Shared or Modified:

- **Shared** is a read-only copy, and other caches may hold the same line.
- **Modified** is the only valid copy, and it may be written.

Processor reads and writes that the current state cannot satisfy go out as bus requests. A read that misses asks for a plain bus read. A write that is not already Modified asks for a read-exclusive. The request waits with ready low until the bus arbiter grants it. The state changes in the grant cycle.

At the same time, the block watches the bus for transactions issued by other caches. It downgrades or invalidates the addressed line. When it holds the line Modified, it raises a flush strobe so that the data can be supplied.

Snoops always win over local requests. If a snoop and a local request address the same line in one cycle, the snoop changes the line first. The local request is then judged against the new state. Snoop traffic tagged with this cache's own source identifier is ignored. Data storage, replacement and eviction are handled elsewhere.

Top module: `msi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid. A read to any line then raises `bus_req`.
- R2: A read to an Invalid line raises `bus_req` with `bus_op` = 0 (read). When `bus_gnt` is high in that cycle, `cpu_ready` is high and the line becomes Shared.
- R3: A read to a Shared or Modified line raises `cpu_ready` in the same cycle, with `bus_req` low. The line state is unchanged.
- R4: A write to an Invalid or Shared line raises `bus_req` with `bus_op` = 1 (read-exclusive). When `bus_gnt` is high in that cycle, `cpu_ready` is high and the line becomes Modified.
- R5: A write to a Modified line raises `cpu_ready` in the same cycle, with `bus_req` low. The line stays Modified.
- R6: A foreign snooped read (`snp_op` = 0) behaves as follows:
  - On a Modified line, it raises `snp_flush` in that cycle and leaves the line Shared.
  - On a Shared or Invalid line, it leaves the state unchanged and `snp_flush` low.
- R7: A foreign snooped read-exclusive (`snp_op` = 1) behaves as follows:
  - On a Modified line, it raises `snp_flush` and leaves the line Invalid.
  - On a Shared line, it leaves the line Invalid without a flush.
  - On an Invalid line, it does nothing.
- R8: A snoop whose `snp_src` equals the parameter `MY_ID` is ignored. No flush is raised and no line changes.
- R9: When a foreign snoop and a local request address the same line in one cycle:
  - The snoop's transition (and flush) applies first.
  - `bus_req` and `cpu_ready` follow from the state after the snoop.
  - A granted local request sets the final state.
- R10: While `bus_req` is high and `bus_gnt` is low, `cpu_ready` stays low and the requested line's state does not change because of the request.
- R11: A snoop or local request changes only the line it addresses. All other lines keep their state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request valid |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_idx | input | IDX_W | Line index of the processor request |
| cpu_ready | output | 1 | Request completes this cycle |
| bus_req | output | 1 | Bus transaction wanted for the current request |
| bus_op | output | 1 | 0 = bus read, 1 = bus read-exclusive |
| bus_idx | output | IDX_W | Line index of the bus transaction |
| bus_gnt | input | 1 | Arbiter grant for `bus_req` |
| snp_valid | input | 1 | A bus transaction is visible this cycle |
| snp_op | input | 1 | 0 = read, 1 = read-exclusive |
| snp_idx | input | IDX_W | Line index of the snooped transaction |
| snp_src | input | SRC_W | Identifier of the issuing cache |
| snp_flush | output | 1 | This cache supplies the line (it held it Modified) |

## Verification
A wrong internal state in this block does not stay hidden for long. It shows up at the ports on the next access to the affected line:

- **Line left Invalid by mistake:** the next read raises `bus_req` where a hit was due.
- **Line wrongly left Modified:** a later snoop gives a spurious `snp_flush`, or a write hits without going to the bus.
- **Line wrongly left Shared:** a write asks for a read-exclusive it does not need.

The bench therefore drives each line into each state and applies every request and snoop kind. It then reads the resulting state back in a single cycle, using a read and a write that are never granted. The same probe is applied to a neighbouring line to catch changes that leak across lines.

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl #(
  parameter int NLINES = 8,
  parameter int SRC_W = 2,
  parameter logic [SRC_W-1:0] MY_ID = '0,
  localparam int IDX_W = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req,
  input  logic             cpu_wr,
  input  logic [IDX_W-1:0] cpu_idx,
  output logic             cpu_ready,
  output logic             bus_req,
  output logic             bus_op,
  output logic [IDX_W-1:0] bus_idx,
  input  logic             bus_gnt,
  input  logic             snp_valid,
  input  logic             snp_op,
  input  logic [IDX_W-1:0] snp_idx,
  input  logic [SRC_W-1:0] snp_src,
  output logic             snp_flush
);

  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_M = 2'd2} mstate_t;

  mstate_t st [NLINES];
  mstate_t snp_cur, snp_nxt, cpu_cur, cpu_nxt;
  logic    snp_hit, cpu_hit, same_line;

  assign snp_hit   = snp_valid && (snp_src != MY_ID);
  assign same_line = snp_hit && (snp_idx == cpu_idx);

  always_comb begin
    snp_cur = st[snp_idx];
    snp_nxt = snp_cur;
    if (snp_hit) begin
      case (snp_cur)
        ST_M:    snp_nxt = snp_op ? ST_I : ST_S;
        ST_S:    snp_nxt = snp_op ? ST_I : ST_S;
        default: snp_nxt = snp_cur;
      endcase
    end
  end

  always_comb begin
    cpu_cur = same_line ? snp_nxt : st[cpu_idx];
    cpu_hit = cpu_wr ? (cpu_cur == ST_M) : (cpu_cur != ST_I);
    if (cpu_wr)              cpu_nxt = ST_M;
    else if (cpu_cur == ST_I) cpu_nxt = ST_S;
    else                     cpu_nxt = cpu_cur;
  end

  assign bus_req   = cpu_req && !cpu_hit;
  assign bus_op    = cpu_wr;
  assign bus_idx   = cpu_idx;
  assign cpu_ready = cpu_req && (cpu_hit || bus_gnt);
  assign snp_flush = snp_hit && (snp_cur == ST_M);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NLINES; i++) st[i] <= ST_I;
    end else begin
      if (snp_hit)   st[snp_idx] <= snp_nxt;
      if (cpu_ready) st[cpu_idx] <= cpu_nxt;
    end
  end

  always_comb begin
    for (int i = 0; i < NLINES; i++)
      assert (!rst_n || st[i] != 2'd3); // R1
  end

  AST_RDMISS_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && bus_req && !cpu_wr |=> st[$past(cpu_idx)] == ST_S); // R2

  AST_WRITE_MODIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && cpu_wr |=> st[$past(cpu_idx)] == ST_M); // R4

  AST_FLUSH_LEAVES_M: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush && !(cpu_ready && cpu_idx == snp_idx) |=> st[$past(snp_idx)] != ST_M); // R6

  AST_RDX_INVALIDATES: assert property (@(posedge clk) disable iff (!rst_n)
    snp_hit && snp_op && !(cpu_ready && cpu_idx == snp_idx) |=> st[$past(snp_idx)] == ST_I); // R7

  AST_OWN_SNOOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_src == MY_ID |-> !snp_flush); // R8

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt && !(snp_hit && snp_idx == cpu_idx)
    |=> st[$past(cpu_idx)] == $past(st[cpu_idx])); // R10

endmodule

// File: tb/sim_msi_line_ctrl.sv
`timescale 1ns/1ps
module sim_msi_line_ctrl;
  localparam int NL = 4;
  localparam int SW = 2;
  localparam logic [SW-1:0] ME = 2'd1;
  localparam logic [SW-1:0] OTHER = 2'd2;
  localparam int SI = 0, SS = 1, SM = 2;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_wr = 0, bus_gnt = 0;
  logic snp_valid = 0, snp_op = 0;
  logic [1:0] cpu_idx = 0, snp_idx = 0, bus_idx;
  logic [SW-1:0] snp_src = 0;
  logic cpu_ready, bus_req, bus_op, snp_flush;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  msi_line_ctrl #(.NLINES(NL), .SRC_W(SW), .MY_ID(ME)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_idx(cpu_idx),
    .cpu_ready(cpu_ready), .bus_req(bus_req), .bus_op(bus_op), .bus_idx(bus_idx),
    .bus_gnt(bus_gnt), .snp_valid(snp_valid), .snp_op(snp_op), .snp_idx(snp_idx),
    .snp_src(snp_src), .snp_flush(snp_flush));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic quiet();
    cpu_req = 0; cpu_wr = 0; bus_gnt = 0; snp_valid = 0; snp_op = 0;
  endtask

  task automatic do_reset();
    quiet();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic probe(int idx, output int s);
    cpu_req = 1; cpu_wr = 0; cpu_idx = idx[1:0];
    #1;
    if (bus_req) s = SI;
    else begin
      cpu_wr = 1;
      #1;
      s = bus_req ? SS : SM;
    end
    quiet();
    @(negedge clk);
  endtask

  task automatic cpu_do(bit wr, int idx);
    cpu_req = 1; cpu_wr = wr; cpu_idx = idx[1:0];
    #1;
    bus_gnt = bus_req;
    #1;
    @(negedge clk);
    quiet();
  endtask

  task automatic set_state(int idx, int s);
    if (s == SS) cpu_do(0, idx);
    if (s == SM) cpu_do(1, idx);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int s;
    int exp_s, exp_req, exp_flush;
    @(negedge clk);
    do_reset();

    for (int i = 0; i < NL; i++) begin
      probe(i, s);
      chk("R1 reset line invalid", s, SI);
    end

    for (int st0 = 0; st0 < 3; st0++) begin
      for (int op = 0; op < 5; op++) begin
        do_reset();
        set_state(1, SS);
        set_state(2, st0);
        exp_req = 0; exp_flush = 0; exp_s = st0;
        case (op)
          0: begin exp_req = (st0 == SI); exp_s = (st0 == SI) ? SS : st0; end
          1: begin exp_req = (st0 != SM); exp_s = SM; end
          2: begin exp_flush = (st0 == SM); exp_s = (st0 == SM) ? SS : st0; end
          3: begin exp_flush = (st0 == SM); exp_s = SI; end
          default: ;
        endcase
        if (op < 2) begin
          cpu_req = 1; cpu_wr = (op == 1); cpu_idx = 2; bus_gnt = 1;
        end else begin
          snp_valid = 1; snp_idx = 2; snp_op = (op != 2);
          snp_src = (op == 4) ? ME : OTHER;
        end
        #1;
        if (op == 0) begin
          chk(st0 == SI ? "R2 read miss bus_req" : "R3 read hit no bus_req", bus_req, exp_req);
          chk("R2/R3 read ready", cpu_ready, 1);
          if (exp_req) chk("R2 bus_op read", bus_op, 0);
        end else if (op == 1) begin
          chk(st0 == SM ? "R5 write hit no bus_req" : "R4 write miss bus_req", bus_req, exp_req);
          chk("R4/R5 write ready", cpu_ready, 1);
          if (exp_req) chk("R4 bus_op read-exclusive", bus_op, 1);
        end else if (op == 2) chk("R6 snoop read flush", snp_flush, exp_flush);
        else if (op == 3) chk("R7 snoop rdx flush", snp_flush, exp_flush);
        else chk("R8 own snoop no flush", snp_flush, 0);
        @(negedge clk);
        quiet();
        probe(2, s);
        case (op)
          0: chk(st0 == SI ? "R2 read miss -> S" : "R3 read hit unchanged", s, exp_s);
          1: chk(st0 == SM ? "R5 write hit stays M" : "R4 write -> M", s, exp_s);
          2: chk("R6 snoop read state", s, exp_s);
          3: chk("R7 snoop rdx state", s, exp_s);
          default: chk("R8 own snoop state unchanged", s, exp_s);
        endcase
        probe(1, s);
        chk("R11 neighbour line unchanged", s, SS);
      end
    end

    do_reset();
    cpu_req = 1; cpu_wr = 1; cpu_idx = 3;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R10 stall bus_req held", bus_req, 1);
      chk("R10 stall ready low", cpu_ready, 0);
      @(negedge clk);
    end
    quiet();
    probe(3, s);
    chk("R10 stall state unchanged", s, SI);
    cpu_req = 1; cpu_wr = 1; cpu_idx = 3; bus_gnt = 1;
    #1;
    chk("R4 granted after stall", cpu_ready, 1);
    @(negedge clk);
    quiet();
    probe(3, s);
    chk("R4 stalled write -> M", s, SM);

    do_reset();
    set_state(0, SM);
    cpu_req = 1; cpu_wr = 0; cpu_idx = 0;
    snp_valid = 1; snp_op = 1; snp_idx = 0; snp_src = OTHER;
    #1;
    chk("R9 collision flush", snp_flush, 1);
    chk("R9 read re-evaluated needs bus", bus_req, 1);
    chk("R9 read not ready without grant", cpu_ready, 0);
    @(negedge clk);
    quiet();
    probe(0, s);
    chk("R9 snoop applied first -> I", s, SI);

    do_reset();
    set_state(0, SM);
    cpu_req = 1; cpu_wr = 1; cpu_idx = 0; bus_gnt = 1;
    snp_valid = 1; snp_op = 0; snp_idx = 0; snp_src = OTHER;
    #1;
    chk("R9 write after snoop read needs bus", bus_req, 1);
    chk("R9 write flush", snp_flush, 1);
    chk("R9 write granted", cpu_ready, 1);
    @(negedge clk);
    quiet();
    probe(0, s);
    chk("R9 granted write wins -> M", s, SM);

    do_reset();
    set_state(0, SS);
    cpu_req = 1; cpu_wr = 0; cpu_idx = 0; bus_gnt = 1;
    snp_valid = 1; snp_op = 1; snp_idx = 0; snp_src = OTHER;
    #1;
    chk("R9 read after rdx needs bus", bus_req, 1);
    chk("R9 no flush from S", snp_flush, 0);
    @(negedge clk);
    quiet();
    probe(0, s);
    chk("R9 re-read -> S", s, SS);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule